// File: doc/BRIEF.md
# Three-Stage Stalling Pipeline Core

This block is a small in-order processor core cut into three pipeline stages. The front stage reads a 16-bit instruction word from an external synchronous ROM. The middle stage decodes it and computes a result. The back stage commits that result either to one of two general registers, A and B, or to an external data memory through a single write port. The instruction set has four operations: load an immediate into a register, copy one register into another, add an immediate to a register, and store a register to a 12-bit memory address.

The core has no result bypass. When the instruction in the middle stage needs a register that the instruction in the back stage is about to write, the core holds the front and middle stages for one cycle and sends an empty slot into the back stage. After the commit the held instruction reads the fresh value. The register values and the per-stage valid bits are brought out for debug. Past the last program word the front stage fetches nothing, and the pipeline drains.

Top module: `tri_stage_core`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears the program counter to 0, clears all three stage valid bits, zeroes registers A and B, drives `imemAddr` to 0 while `rst` is high, and keeps `dmemWe` low.
- R2: Instruction word: bits [15:14] are the opcode (00 load-immediate, 01 copy, 10 add-immediate, 11 store). Bit 13 names the destination register (0 = A, 1 = B); for a store it names the register whose value is written. Bit 12 names the copy source (0 = A, 1 = B). Bits [11:0] are the zero-extended immediate or the store address. A register changes only when a load, copy or add commits.
- R3: With no dependencies the core takes one new instruction per cycle. An instruction fetched in cycle c commits in cycle c+2, and three instructions are in flight at once. After reset release, the word at address 0 is fetched in cycle 1, where cycle 0 is the cycle right after the last reset edge.
- R4: A store commits by raising `dmemWe` for exactly one cycle while it is in the back stage, with `dmemAddr` equal to bits [11:0] and `dmemData` equal to the named register. No register is written in that cycle.
- R5: If the middle-stage instruction reads a register that the valid back-stage instruction writes, it waits one cycle. The program {load A,#40; copy B,A; add B,#20; store 0x300,B} writes 60 to address 0x300 in cycle 9.
- R6: During a stall the back stage receives an empty slot (`stageValid[2]` = 0 in the next cycle). The front and middle stages keep their instructions, `imemAddr` repeats its value, and the older back-stage instruction still commits.
- R7: No stall occurs when the consumer is a load-immediate, when the back-stage instruction is a store, or when the registers differ.
- R8: Each stall cycle delays completion of the later instructions by exactly one cycle relative to the stall-free schedule.
- R9: The number of program words is fixed by a parameter. Once the program counter reaches it, the counter stops, the front stage stays invalid, the pipeline drains to all valid bits 0, and no further writes occur.
- R10: The ROM port is synchronous. `imemAddr` carries the address whose word must appear on `imemData` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imemAddr | output | PC_W | Address presented to the synchronous instruction ROM |
| imemData | input | 16 | ROM word for the address presented one cycle earlier |
| dmemWe | output | 1 | Data memory write strobe |
| dmemAddr | output | 12 | Data memory write address |
| dmemData | output | DATA_W | Data memory write value |
| regA | output | DATA_W | Debug view of register A |
| regB | output | DATA_W | Debug view of register B |
| stageValid | output | 3 | Debug valid bits {back, middle, front} |

## Verification
The hardest case to produce is a chain of stalls in which every instruction depends on the one just before it. In that case the ROM address must be held and the back stage must be emptied in alternating cycles, while the older instruction still commits. The test program builds exactly that chain, and the bench samples the valid bits and the ROM address in the stall cycle and in the cycle after it. Separate short programs put a non-matching producer, a store producer and a load consumer next to each other to show that no false stall appears. A reset in the middle of the run confirms that state held in flight is dropped.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  localparam int INSTR_W = 16;
  localparam int IMM_W   = 12;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_MOVE  = 2'b01,
    OP_ADD   = 2'b10,
    OP_STORE = 2'b11
  } op_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic stall;
    logic xLoad;
    logic sLoad;
    logic regWe;
    logic memWe;
  } strobe_t;
endpackage

// File: rtl/tsp_control.sv
module tsp_control
  import tsp_pkg::*;
#(
  parameter int PC_W       = 8,
  parameter int PROG_WORDS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            xReads,
  input  logic            xWrites,
  input  logic            xSrc,
  input  logic            sDst,
  output strobe_t         strobes,
  output logic [PC_W-1:0] pcNext,
  output logic [2:0]      stageValid
);
  localparam logic [PC_W-1:0] LAST_PC = PC_W'(PROG_WORDS);

  logic            started;
  logic [PC_W-1:0] pc;
  logic            xValid, sValid, sWrites;
  logic            fetchValid, stall;

  assign fetchValid = started && (pc < LAST_PC);
  assign stall      = xValid && xReads && sValid && sWrites && (xSrc == sDst);

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      pc      <= '0;
      xValid  <= 1'b0;
      sValid  <= 1'b0;
      sWrites <= 1'b0;
    end else begin
      started <= 1'b1;
      if (!stall) begin
        xValid  <= fetchValid;
        sValid  <= xValid;
        sWrites <= xWrites;
        if (fetchValid) pc <= pc + 1'b1;
      end else begin
        sValid <= 1'b0;
      end
    end
  end

  always_comb begin
    if (rst || !started)         pcNext = '0;
    else if (fetchValid && !stall) pcNext = pc + 1'b1;
    else                         pcNext = pc;
  end

  assign strobes.stall = stall;
  assign strobes.xLoad = !stall;
  assign strobes.sLoad = !stall && xValid;
  assign strobes.regWe = sValid && sWrites;
  assign strobes.memWe = sValid && !sWrites;

  assign stageValid = {sValid, xValid, fetchValid};
endmodule

// File: rtl/tsp_datapath.sv
module tsp_datapath
  import tsp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            strobes,
  input  logic [INSTR_W-1:0] imemData,
  output logic               xReads,
  output logic               xWrites,
  output logic               xSrc,
  output logic               sDst,
  output logic [IMM_W-1:0]   dmemAddr,
  output logic [DATA_W-1:0]  dmemData,
  output logic [DATA_W-1:0]  regA,
  output logic [DATA_W-1:0]  regB
);
  logic [INSTR_W-1:0] xInstr;
  op_e                xOp;
  logic               xDstSel, xMovSel;
  logic [DATA_W-1:0]  immExt, srcVal, xResult;
  logic [DATA_W-1:0]  sResult;
  logic [IMM_W-1:0]   sAddr;

  always_ff @(posedge clk) begin
    if (rst)                xInstr <= '0;
    else if (strobes.xLoad) xInstr <= imemData;
  end

  assign xOp     = op_e'(xInstr[15:14]);
  assign xDstSel = xInstr[13];
  assign xMovSel = xInstr[12];
  assign immExt  = DATA_W'(xInstr[IMM_W-1:0]);

  assign xReads  = (xOp != OP_LOAD);
  assign xWrites = (xOp != OP_STORE);
  assign xSrc    = (xOp == OP_MOVE) ? xMovSel : xDstSel;
  assign srcVal  = xSrc ? regB : regA;

  always_comb begin
    unique case (xOp)
      OP_LOAD: xResult = immExt;
      OP_ADD:  xResult = srcVal + immExt;
      default: xResult = srcVal;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sResult <= '0;
      sDst    <= 1'b0;
      sAddr   <= '0;
    end else if (strobes.sLoad) begin
      sResult <= xResult;
      sDst    <= xDstSel;
      sAddr   <= xInstr[IMM_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regA <= '0;
      regB <= '0;
    end else if (strobes.regWe) begin
      if (sDst) regB <= sResult;
      else      regA <= sResult;
    end
  end

  assign dmemAddr = sAddr;
  assign dmemData = sResult;
endmodule

// File: rtl/tri_stage_core.sv
module tri_stage_core
  import tsp_pkg::*;
#(
  parameter int PC_W       = 8,
  parameter int DATA_W     = 16,
  parameter int PROG_WORDS = 16
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PC_W-1:0]    imemAddr,
  input  logic [15:0]        imemData,
  output logic               dmemWe,
  output logic [11:0]        dmemAddr,
  output logic [DATA_W-1:0]  dmemData,
  output logic [DATA_W-1:0]  regA,
  output logic [DATA_W-1:0]  regB,
  output logic [2:0]         stageValid
);
  strobe_t strobes;
  logic    xReads, xWrites, xSrc, sDst;

  tsp_control #(.PC_W(PC_W), .PROG_WORDS(PROG_WORDS)) u_ctrl (
    .clk(clk), .rst(rst),
    .xReads(xReads), .xWrites(xWrites), .xSrc(xSrc), .sDst(sDst),
    .strobes(strobes), .pcNext(imemAddr), .stageValid(stageValid)
  );

  tsp_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .imemData(imemData),
    .xReads(xReads), .xWrites(xWrites), .xSrc(xSrc), .sDst(sDst),
    .dmemAddr(dmemAddr), .dmemData(dmemData), .regA(regA), .regB(regB)
  );

  assign dmemWe = strobes.memWe;
endmodule

// File: rtl/tsp_checker.sv
module tsp_checker #(
  parameter int PC_W       = 8,
  parameter int DATA_W     = 16,
  parameter int PROG_WORDS = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [PC_W-1:0]   imemAddr,
  input logic              dmemWe,
  input logic [DATA_W-1:0] regA,
  input logic [DATA_W-1:0] regB,
  input logic [2:0]        stageValid,
  input logic              stall,
  input logic              regWe
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (stageValid == 3'b000 && regA == '0 && regB == '0)); // R1
  AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (rst) stall |=> !stageValid[2]); // R6
  AST_STALL_KEEPS_MIDDLE: assert property (@(posedge clk) disable iff (rst) stall |=> stageValid[1]); // R6
  AST_STALL_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst) stall |-> imemAddr == $past(imemAddr)); // R10
  AST_STORE_IN_BACK: assert property (@(posedge clk) disable iff (rst) dmemWe |-> stageValid[2]); // R4
  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (rst) $onehot0({dmemWe, regWe})); // R4
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst) !regWe |=> ($stable(regA) && $stable(regB))); // R2
  AST_PC_BOUND: assert property (@(posedge clk) disable iff (rst) imemAddr <= PC_W'(PROG_WORDS)); // R9
endmodule

bind tri_stage_core tsp_checker #(.PC_W(PC_W), .DATA_W(DATA_W), .PROG_WORDS(PROG_WORDS)) u_chk (
  .clk(clk), .rst(rst), .imemAddr(imemAddr), .dmemWe(dmemWe),
  .regA(regA), .regB(regB), .stageValid(stageValid),
  .stall(strobes.stall), .regWe(strobes.regWe)
);

// File: tb/tri_stage_core_bench.sv
`timescale 1ns/1ps
module tri_stage_core_bench;
  localparam int PC_W = 8;
  localparam int DATA_W = 16;
  localparam int PROG_WORDS = 8;
  localparam logic [15:0] PAD = 16'h4000; // copy A <- A

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PC_W-1:0] imemAddr;
  logic [15:0] imemData;
  logic dmemWe;
  logic [11:0] dmemAddr;
  logic [DATA_W-1:0] dmemData, regA, regB;
  logic [2:0] stageValid;

  int errors = 0;
  int checks = 0;
  int cycCnt = 0;
  bit done = 1'b0;

  logic [15:0] rom [0:15];
  int wrN;
  int wrCyc [0:7];
  logic [11:0] wrAddr [0:7];
  logic [DATA_W-1:0] wrData [0:7];

  always #2 clk = ~clk;

  tri_stage_core #(.PC_W(PC_W), .DATA_W(DATA_W), .PROG_WORDS(PROG_WORDS)) u_tri_stage_core (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData),
    .dmemWe(dmemWe), .dmemAddr(dmemAddr), .dmemData(dmemData),
    .regA(regA), .regB(regB), .stageValid(stageValid)
  );

  always @(posedge clk) imemData <= rom[imemAddr[3:0]];
  always @(posedge clk) cycCnt <= rst ? 0 : cycCnt + 1;

  always @(negedge clk) begin
    if (rst) wrN = 0;
    else if (dmemWe && wrN < 8) begin
      wrCyc[wrN] = cycCnt;
      wrAddr[wrN] = dmemAddr;
      wrData[wrN] = dmemData;
      wrN = wrN + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic loadProg(input logic [15:0] w0, input logic [15:0] w1,
                          input logic [15:0] w2, input logic [15:0] w3);
    for (int i = 0; i < 16; i++) rom[i] = PAD;
    rom[0] = w0; rom[1] = w1; rom[2] = w2; rom[3] = w3;
  endtask

  task automatic doReset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic atCycle(input int c);
    while (cycCnt < c) @(negedge clk);
  endtask

  // Main dependent program: three stalls
  task automatic testChain();
    loadProg(16'h0028, 16'h6000, 16'hA014, 16'hE300);
    doReset();
    check("R1 valid after reset", stageValid, 3'b000);
    check("R1 regA after reset", regA, 0);
    check("R1 regB after reset", regB, 0);
    atCycle(1);
    check("R10 addr cycle1", imemAddr, 1);
    check("R3 front valid cycle1", stageValid, 3'b001);
    atCycle(3);
    check("R6 all stages busy at stall", stageValid, 3'b111);
    check("R6 r10_ addr held in stall", imemAddr, 2);
    atCycle(4);
    check("R6 bubble in back stage", stageValid, 3'b011);
    check("R6 addr advances after stall", imemAddr, 3);
    check("R6 older load committed", regA, 40);
    atCycle(12);
    check("R5 one store", wrN, 1);
    check("R5 store addr", wrAddr[0], 12'h300);
    check("R5 store data", wrData[0], 60);
    check("R8 store cycle with three stalls", wrCyc[0], 9);
    atCycle(40);
    check("R9 drained", stageValid, 3'b000);
    check("R9 pc stopped", imemAddr, PROG_WORDS);
    check("R9 no extra writes", wrN, 1);
    check("R2 regA final", regA, 40);
    check("R2 regB final", regB, 60);
  endtask

  task automatic testIndependent();
    loadProg(16'h0005, 16'h2007, 16'hC011, 16'hE012);
    doReset();
    atCycle(3);
    check("R3 three in flight", stageValid, 3'b111);
    atCycle(10);
    check("R3 two stores", wrN, 2);
    check("R3 first store cycle", wrCyc[0], 5);
    check("R3 second store cycle", wrCyc[1], 6);
    check("R4 first store addr", wrAddr[0], 12'h011);
    check("R4 first store data", wrData[0], 5);
    check("R4 second store addr", wrAddr[1], 12'h012);
    check("R4 second store data", wrData[1], 7);
  endtask

  task automatic testSingleStall();
    loadProg(16'h0003, 16'h8004, 16'h2009, 16'hC020);
    doReset();
    atCycle(10);
    check("R8 one stall store cycle", wrCyc[0], 7);
    check("R8 one stall store data", wrData[0], 7);
    check("R2 add result in regA", regA, 7);
  endtask

  task automatic testNoFalseHazard();
    loadProg(16'h0001, 16'h0002, 16'h2003, 16'hC031);
    doReset();
    atCycle(3);
    check("R7 load consumer no stall", stageValid, 3'b111);
    atCycle(4);
    check("R7 no bubble after load pair", stageValid, 3'b111);
    atCycle(10);
    check("R7 store cycle", wrCyc[0], 6);
    check("R7 store data", wrData[0], 2);
  endtask

  task automatic testMoveSource();
    loadProg(16'h2123, 16'h5000, PAD, PAD);
    doReset();
    atCycle(20);
    check("R2 copy source bit12", regA, 16'h0123);
    check("R2 copy keeps source", regB, 16'h0123);
  endtask

  task automatic testMidReset();
    loadProg(16'h0028, 16'h6000, 16'hA014, 16'hE300);
    doReset();
    atCycle(5);
    rst = 1'b1;
    @(negedge clk);
    check("R1 regA cleared", regA, 0);
    check("R1 regB cleared", regB, 0);
    check("R1 valid cleared", stageValid, 3'b000);
    check("R1 addr zero", imemAddr, 0);
    check("R1 no write in reset", dmemWe, 0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) rom[i] = PAD;
    testChain();
    testIndependent();
    testSingleStall();
    testNoFalseHazard();
    testMoveSource();
    testMidReset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule